// File: doc/BRIEF.md
# SD Operating-Condition Negotiation Controller

This block runs the supply-voltage and operating-condition handshake that opens SD card initialization. When a card is attached, it first asks a command engine to put the bus at 3.3 V signalling. It then builds the 32-bit argument for the operating-condition command and issues that command. Three inputs shape the argument: the interface-condition result, the host's UHS-I mode capabilities, and the per-rail maximum-current fields. The block reads the card's response word and decides whether to ask the engine to move the bus to 1.8 V signalling. If that switch fails, the block clears its switch request and sends the operating-condition command once more.

Every step is handed to an external command engine. The block raises a request together with a step kind and an argument. The engine finishes the step with a one-cycle done strobe, an error flag and a response word. The outcome is reported as a one-cycle completion pulse, a sticky error flag and a level that shows whether the card ended at 1.8 V.

Top module: `sd_opcond_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `cmd_req_o`, `done_o`, `err_o` and `low_volt_o` are 0.
- R2: A pulse on `attach_i` is honoured in any state, including in the middle of a sequence. In the following cycle the block requests step kind 0 (3.3 V signalling) with argument 0, and no operating-condition step comes before it. The same pulse clears `err_o` and `low_volt_o`.
- R3: In the operating-condition step (kind 1), argument bit 30 equals `ifcond_ok_i` as sampled on the attach pulse.
- R4: In the operating-condition step, argument bit 24 is set exactly when at least one bit of `uhs_caps_i` was set at attach.
- R5: Argument bit 28 is set exactly when some rail i has `rail_en_i[i]`=1 and a current field whose value times 4 is strictly greater than 150. Rail 0 (3.3 V) uses bits 7:0, rail 1 (3.0 V) uses bits 15:8 and rail 2 (1.8 V) uses bits 23:16. A field of 38 passes and 37 does not. All other argument bits are 0.
- R6: When the operating-condition step finishes without error, the block requests step kind 2 (1.8 V switch, argument 0) only if all three hold: response bits 30 and 24 are both set, argument bit 24 is set, and `spi_mode_i` is 0. Otherwise the sequence completes at 3.3 V.
- R7: If the engine reports an error on the switch step, the next request is kind 1 with argument bit 24 cleared and every other bit unchanged. Because that argument no longer asks for the switch, at most one retry occurs.
- R8: An engine error on step kind 0 or kind 1 ends the sequence. `done_o` pulses, `err_o` goes high and stays high with no request raised until the next attach.
- R9: `done_o` is a single-cycle pulse at the end of every sequence. `low_volt_o` becomes 1 only when the switch step completes without error.
- R10: `cmd_req_o` and `cmd_kind_o` hold until `cmd_done_i` is sampled high. A `cmd_done_i` pulse while no request is raised changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attach_i | input | 1 | One-cycle pulse: card inserted, start the sequence |
| ifcond_ok_i | input | 1 | Interface-condition command succeeded |
| spi_mode_i | input | 1 | Bus is in SPI mode, voltage switch forbidden |
| uhs_caps_i | input | 5 | Host UHS-I mode capability bits |
| rail_en_i | input | 3 | Voltage-support bit per rail (0: 3.3 V, 1: 3.0 V, 2: 1.8 V) |
| rail_cur_i | input | 24 | Three 8-bit maximum-current fields, unit 4 mA |
| cmd_req_o | output | 1 | Step request to the command engine |
| cmd_kind_o | output | 2 | Step kind: 0 set 3.3 V, 1 operating condition, 2 switch to 1.8 V |
| cmd_arg_o | output | 32 | Command argument (non-zero only for kind 1) |
| cmd_done_i | input | 1 | One-cycle strobe: requested step finished |
| cmd_err_i | input | 1 | Step failed, valid with `cmd_done_i` |
| cmd_resp_i | input | 32 | Response word, valid with `cmd_done_i` |
| done_o | output | 1 | One-cycle pulse: sequence finished |
| err_o | output | 1 | Sequence aborted on an engine error |
| low_volt_o | output | 1 | Card now signals at 1.8 V |

## Verification
The properties assume that the command engine raises `cmd_done_i` only while a request is pending, and that response and error values have meaning only in that strobe cycle. The stimulus keeps to this by replying only after it has seen the request. The one exception is a deliberate stray strobe in the idle state, which exercises R10. The properties also assume that the capability inputs are stable when `attach_i` pulses. The bench changes them only on the falling edge before the attach pulse. It uses current fields on both sides of the 150 mA limit and gates each rail with its enable bit.

// File: rtl/sd_ocr_pkg.sv
package sd_ocr_pkg;
  localparam int ARG_W   = 32;
  localparam int BIT_S18 = 24;
  localparam int BIT_XPC = 28;
  localparam int BIT_CCS = 30;

  typedef enum logic [1:0] {
    KIND_SIG33  = 2'd0,
    KIND_OPCOND = 2'd1,
    KIND_SW18   = 2'd2
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SIG33 = 2'd1,
    ST_OPC   = 2'd2,
    ST_SW18  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rail_current_cmp.sv
module rail_current_cmp #(
  parameter int CUR_W     = 8,
  parameter int CUR_MULT  = 4,
  parameter int CUR_LIMIT = 150
) (
  input  logic             rail_en,
  input  logic [CUR_W-1:0] field,
  output logic             over
);
  localparam int PW = CUR_W + 16;
  logic [PW-1:0] milliamps;

  always_comb begin
    milliamps = PW'(field) * PW'(CUR_MULT);
    over      = rail_en && (milliamps > PW'(CUR_LIMIT));
  end
endmodule

// File: rtl/ocr_arg_builder.sv
module ocr_arg_builder
  import sd_ocr_pkg::*;
#(
  parameter int UHS_N     = 5,
  parameter int RAIL_N    = 3,
  parameter int CUR_W     = 8,
  parameter int CUR_MULT  = 4,
  parameter int CUR_LIMIT = 150
) (
  input  logic                    ifcond_ok,
  input  logic [UHS_N-1:0]        uhs_caps,
  input  logic [RAIL_N-1:0]       rail_en,
  input  logic [RAIL_N*CUR_W-1:0] rail_cur,
  output logic [ARG_W-1:0]        arg
);
  logic [RAIL_N-1:0] rail_over;

  for (genvar g = 0; g < RAIL_N; g++) begin : g_rail
    rail_current_cmp #(
      .CUR_W(CUR_W), .CUR_MULT(CUR_MULT), .CUR_LIMIT(CUR_LIMIT)
    ) u_cmp (
      .rail_en(rail_en[g]),
      .field  (rail_cur[g*CUR_W +: CUR_W]),
      .over   (rail_over[g])
    );
  end

  always_comb begin
    arg          = '0;
    arg[BIT_CCS] = ifcond_ok;
    arg[BIT_S18] = |uhs_caps;
    arg[BIT_XPC] = |rail_over;
  end
endmodule

// File: rtl/switch_decider.sv
module switch_decider
  import sd_ocr_pkg::*;
(
  input  logic [ARG_W-1:0] resp,
  input  logic             s18_requested,
  input  logic             spi_mode,
  output logic             start_switch
);
  localparam logic [ARG_W-1:0] ACCEPT_MASK =
    (ARG_W'(1) << BIT_CCS) | (ARG_W'(1) << BIT_S18);

  always_comb begin
    start_switch = ((resp & ACCEPT_MASK) == ACCEPT_MASK) && s18_requested && !spi_mode;
  end
endmodule

// File: rtl/ocr_seq.sv
module ocr_seq
  import sd_ocr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             attach,
  input  logic [ARG_W-1:0] arg_new,
  input  logic             start_switch,
  input  logic             step_done,
  input  logic             step_err,
  output logic [ARG_W-1:0] arg_cur,
  output logic             req,
  output cmd_kind_e        kind,
  output logic [ARG_W-1:0] arg_out,
  output logic             seq_done,
  output logic             seq_err,
  output logic             low_volt
);
  seq_state_e       st_q, st_d;
  logic [ARG_W-1:0] arg_q, arg_d;
  logic             arg_en;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             lv_q, lv_d;

  always_comb begin
    st_d   = st_q;
    arg_d  = arg_q;
    arg_en = 1'b0;
    done_d = 1'b0;
    err_d  = err_q;
    lv_d   = lv_q;
    if (attach) begin
      st_d   = ST_SIG33;
      arg_d  = arg_new;
      arg_en = 1'b1;
      err_d  = 1'b0;
      lv_d   = 1'b0;
    end else if (step_done && st_q != ST_IDLE) begin
      unique case (st_q)
        ST_SIG33: begin
          if (step_err) begin
            st_d = ST_IDLE; err_d = 1'b1; done_d = 1'b1;
          end else begin
            st_d = ST_OPC;
          end
        end
        ST_OPC: begin
          if (step_err) begin
            st_d = ST_IDLE; err_d = 1'b1; done_d = 1'b1;
          end else if (start_switch) begin
            st_d = ST_SW18;
          end else begin
            st_d = ST_IDLE; done_d = 1'b1;
          end
        end
        ST_SW18: begin
          if (step_err) begin
            st_d           = ST_OPC;
            arg_d          = arg_q;
            arg_d[BIT_S18] = 1'b0;
            arg_en         = 1'b1;
          end else begin
            st_d = ST_IDLE; lv_d = 1'b1; done_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      arg_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      lv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      lv_q   <= lv_d;
      if (arg_en) arg_q <= arg_d;
    end
  end

  always_comb begin
    req = (st_q != ST_IDLE);
    unique case (st_q)
      ST_OPC:  kind = KIND_OPCOND;
      ST_SW18: kind = KIND_SW18;
      default: kind = KIND_SIG33;
    endcase
    arg_out  = (st_q == ST_OPC) ? arg_q : '0;
    arg_cur  = arg_q;
    seq_done = done_q;
    seq_err  = err_q;
    low_volt = lv_q;
  end
endmodule

// File: rtl/sd_opcond_ctrl.sv
module sd_opcond_ctrl
  import sd_ocr_pkg::*;
#(
  parameter int UHS_N     = 5,
  parameter int RAIL_N    = 3,
  parameter int CUR_W     = 8,
  parameter int CUR_MULT  = 4,
  parameter int CUR_LIMIT = 150
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    attach_i,
  input  logic                    ifcond_ok_i,
  input  logic                    spi_mode_i,
  input  logic [UHS_N-1:0]        uhs_caps_i,
  input  logic [RAIL_N-1:0]       rail_en_i,
  input  logic [RAIL_N*CUR_W-1:0] rail_cur_i,
  output logic                    cmd_req_o,
  output logic [1:0]              cmd_kind_o,
  output logic [ARG_W-1:0]        cmd_arg_o,
  input  logic                    cmd_done_i,
  input  logic                    cmd_err_i,
  input  logic [ARG_W-1:0]        cmd_resp_i,
  output logic                    done_o,
  output logic                    err_o,
  output logic                    low_volt_o
);
  logic [ARG_W-1:0] arg_new;
  logic [ARG_W-1:0] arg_cur;
  logic             start_switch;
  cmd_kind_e        kind;

  ocr_arg_builder #(
    .UHS_N(UHS_N), .RAIL_N(RAIL_N), .CUR_W(CUR_W),
    .CUR_MULT(CUR_MULT), .CUR_LIMIT(CUR_LIMIT)
  ) u_build (
    .ifcond_ok(ifcond_ok_i),
    .uhs_caps (uhs_caps_i),
    .rail_en  (rail_en_i),
    .rail_cur (rail_cur_i),
    .arg      (arg_new)
  );

  switch_decider u_decide (
    .resp         (cmd_resp_i),
    .s18_requested(arg_cur[BIT_S18]),
    .spi_mode     (spi_mode_i),
    .start_switch (start_switch)
  );

  ocr_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .attach      (attach_i),
    .arg_new     (arg_new),
    .start_switch(start_switch),
    .step_done   (cmd_done_i),
    .step_err    (cmd_err_i),
    .arg_cur     (arg_cur),
    .req         (cmd_req_o),
    .kind        (kind),
    .arg_out     (cmd_arg_o),
    .seq_done    (done_o),
    .seq_err     (err_o),
    .low_volt    (low_volt_o)
  );

  assign cmd_kind_o = kind;
endmodule

// File: rtl/sd_opcond_ctrl_chk.sv
module sd_opcond_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        attach_i,
  input logic        spi_mode_i,
  input logic        cmd_req_o,
  input logic [1:0]  cmd_kind_o,
  input logic [31:0] cmd_arg_o,
  input logic        cmd_done_i,
  input logic        cmd_err_i,
  input logic [31:0] cmd_resp_i,
  input logic        done_o,
  input logic        err_o,
  input logic        low_volt_o
);
  localparam logic [31:0] BOTH = 32'h4100_0000;
  localparam logic [31:0] LEGAL = 32'h5100_0000;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !cmd_req_o && !done_o && !err_o && !low_volt_o); // R1
  AST_ATTACH_33V: assert property (@(posedge clk) disable iff (!rst_n)
    attach_i |=> cmd_req_o && cmd_kind_o == 2'd0 && cmd_arg_o == 32'h0 && !err_o && !low_volt_o); // R2
  AST_ARG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && cmd_kind_o == 2'd1) |-> (cmd_arg_o & ~LEGAL) == 32'h0); // R5
  AST_SPI_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && cmd_kind_o == 2'd1 && cmd_done_i && !cmd_err_i && !attach_i && spi_mode_i)
    |=> !(cmd_req_o && cmd_kind_o == 2'd2)); // R6
  AST_NO_ACCEPT_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && cmd_kind_o == 2'd1 && cmd_done_i && !attach_i && (cmd_resp_i & BOTH) != BOTH)
    |=> !(cmd_req_o && cmd_kind_o == 2'd2)); // R6
  AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && cmd_kind_o == 2'd2 && cmd_done_i && cmd_err_i && !attach_i)
    |=> cmd_req_o && cmd_kind_o == 2'd1 && !cmd_arg_o[24]); // R7
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !cmd_req_o && !low_volt_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_LV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    low_volt_o |-> !cmd_req_o); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && !cmd_done_i && !attach_i) |=> cmd_req_o && $stable(cmd_kind_o)); // R10
  AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_req_o && !attach_i) |=> !cmd_req_o && $stable(err_o) && $stable(low_volt_o)); // R10
endmodule

bind sd_opcond_ctrl sd_opcond_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .attach_i(attach_i), .spi_mode_i(spi_mode_i),
  .cmd_req_o(cmd_req_o), .cmd_kind_o(cmd_kind_o), .cmd_arg_o(cmd_arg_o),
  .cmd_done_i(cmd_done_i), .cmd_err_i(cmd_err_i), .cmd_resp_i(cmd_resp_i),
  .done_o(done_o), .err_o(err_o), .low_volt_o(low_volt_o)
);

// File: tb/sd_opcond_ctrl_bench.sv
module sd_opcond_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        attach_i = 1'b0;
  logic        ifcond_ok_i = 1'b0;
  logic        spi_mode_i = 1'b0;
  logic [4:0]  uhs_caps_i = '0;
  logic [2:0]  rail_en_i = '0;
  logic [23:0] rail_cur_i = '0;
  logic        cmd_done_i = 1'b0;
  logic        cmd_err_i = 1'b0;
  logic [31:0] cmd_resp_i = '0;
  logic        cmd_req_o;
  logic [1:0]  cmd_kind_o;
  logic [31:0] cmd_arg_o;
  logic        done_o, err_o, low_volt_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sd_opcond_ctrl u_sd_opcond_ctrl (
    .clk(clk), .rst_n(rst_n), .attach_i(attach_i), .ifcond_ok_i(ifcond_ok_i),
    .spi_mode_i(spi_mode_i), .uhs_caps_i(uhs_caps_i), .rail_en_i(rail_en_i),
    .rail_cur_i(rail_cur_i), .cmd_req_o(cmd_req_o), .cmd_kind_o(cmd_kind_o),
    .cmd_arg_o(cmd_arg_o), .cmd_done_i(cmd_done_i), .cmd_err_i(cmd_err_i),
    .cmd_resp_i(cmd_resp_i), .done_o(done_o), .err_o(err_o), .low_volt_o(low_volt_o)
  );

  // Behavioural reference: phase 0 idle, 1 set 3.3 V, 2 op-cond, 3 switch
  int          m_phase = 0;
  logic [31:0] m_arg = '0;
  bit          m_done = 0, m_err = 0, m_lv = 0;

  function automatic logic [31:0] expect_arg();
    logic [31:0] a = '0;
    int ma;
    a[30] = ifcond_ok_i;
    a[24] = (uhs_caps_i != 0);
    for (int i = 0; i < 3; i++) begin
      ma = int'(rail_cur_i[i*8 +: 8]) * 4;
      if (rail_en_i[i] && ma > 150) a[28] = 1'b1;
    end
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_arg = '0; m_done = 0; m_err = 0; m_lv = 0;
    end else begin
      m_done = 0;
      if (attach_i) begin
        m_phase = 1; m_arg = expect_arg(); m_err = 0; m_lv = 0;
      end else if (m_phase != 0 && cmd_done_i) begin
        if (m_phase == 3) begin
          if (cmd_err_i) begin m_arg[24] = 1'b0; m_phase = 2; end
          else begin m_phase = 0; m_lv = 1; m_done = 1; end
        end else if (cmd_err_i) begin
          m_phase = 0; m_err = 1; m_done = 1;
        end else if (m_phase == 1) begin
          m_phase = 2;
        end else if (cmd_resp_i[30] && cmd_resp_i[24] && m_arg[24] && !spi_mode_i) begin
          m_phase = 3;
        end else begin
          m_phase = 0; m_done = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Every-cycle comparison with the reference
  always @(negedge clk) begin
    cycles++;
    if (!finished) begin
      chk("R10 req", 32'(cmd_req_o), 32'(m_phase != 0));
      if (m_phase != 0) chk("R2/R6/R7 kind", 32'(cmd_kind_o), 32'(m_phase - 1));
      chk("R3/R4/R5 arg", cmd_arg_o, (m_phase == 2) ? m_arg : 32'h0);
      chk("R9 done", 32'(done_o), 32'(m_done));
      chk("R8 err", 32'(err_o), 32'(m_err));
      chk("R9 lowvolt", 32'(low_volt_o), 32'(m_lv));
    end
    if (cycles > 20000 && !finished) begin
      failures++;
      finished = 1;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic attach();
    @(negedge clk); attach_i = 1'b1;
    @(negedge clk); attach_i = 1'b0;
  endtask

  task automatic reply(input logic [31:0] resp, input bit err, input int lat);
    repeat (lat) @(negedge clk);
    cmd_done_i = 1'b1; cmd_resp_i = resp; cmd_err_i = err;
    @(negedge clk);
    cmd_done_i = 1'b0; cmd_err_i = 1'b0; cmd_resp_i = '0;
  endtask

  task automatic caps(input bit ifc, input logic [4:0] uhs, input logic [2:0] en,
                      input logic [23:0] cur, input bit spi);
    ifcond_ok_i = ifc; uhs_caps_i = uhs; rail_en_i = en; rail_cur_i = cur; spi_mode_i = spi;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset req", 32'(cmd_req_o), 0);
    chk("R1 reset done", 32'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {29'h0, err_o, low_volt_o, cmd_req_o}, 0);

    // Full switch to 1.8 V; currents 148 mA on every rail
    caps(1, 5'b00001, 3'b111, {8'd37, 8'd37, 8'd37}, 0);
    attach();
    chk("R2 first step kind", 32'(cmd_kind_o), 0);
    chk("R2 first step req", 32'(cmd_req_o), 1);
    repeat (3) @(negedge clk);
    chk("R10 request held", 32'(cmd_req_o), 1);
    reply(32'h0, 0, 0);
    chk("R2 then opcond", 32'(cmd_kind_o), 1);
    chk("R3/R4 arg ccs+s18, R5 no xpc at 148mA", cmd_arg_o, 32'h4100_0000);
    reply(32'hC1FF_8000, 0, 2);
    chk("R6 switch requested", 32'(cmd_kind_o), 2);
    reply(32'h0, 0, 3);
    chk("R9 done pulse", 32'(done_o), 1);
    chk("R9 low volt", 32'(low_volt_o), 1);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'(done_o), 0);

    // Rail 0 at 152 mA, no UHS, no ifcond: response accepted but no request bit
    caps(0, 5'b0, 3'b001, {8'd0, 8'd0, 8'd38}, 0);
    attach();
    reply(32'h0, 0, 1);
    chk("R5 xpc at 152mA", cmd_arg_o, 32'h1000_0000);
    reply(32'h4100_0000, 0, 1);
    chk("R6 no switch without s18 request", 32'(low_volt_o), 0);
    chk("R6 completes at 3.3V", 32'(done_o), 1);

    // Disabled rail with large field gives no xpc; restart mid-sequence
    caps(1, 5'b10000, 3'b110, {8'd37, 8'd37, 8'd255}, 0);
    attach();
    reply(32'h0, 0, 0);
    chk("R5 disabled rail ignored", cmd_arg_o, 32'h4100_0000);
    caps(1, 5'b00100, 3'b100, {8'd38, 8'd0, 8'd0}, 0);
    attach();
    chk("R2 restart from opcond", 32'(cmd_kind_o), 0);
    reply(32'h0, 0, 1);
    chk("R5 1.8V rail xpc", cmd_arg_o, 32'h5100_0000);
    reply(32'h0000_8000, 0, 1);
    chk("R6 card not accepting", 32'(done_o), 1);

    // SPI mode never switches
    caps(1, 5'b00010, 3'b000, 24'h0, 1);
    attach();
    reply(32'h0, 0, 1);
    reply(32'hC100_0000, 0, 1);
    chk("R6 spi no switch", {30'h0, done_o, low_volt_o}, 32'h2);

    // Switch failure: one retry without the request bit
    caps(1, 5'b01000, 3'b001, {8'd0, 8'd0, 8'd40}, 0);
    attach();
    reply(32'h0, 0, 1);
    reply(32'hC100_0000, 0, 1);
    chk("R6 switch step", 32'(cmd_kind_o), 2);
    reply(32'h0, 1, 2);
    chk("R7 retry kind", 32'(cmd_kind_o), 1);
    chk("R7 retry arg", cmd_arg_o, 32'h5000_0000);
    reply(32'hC100_0000, 0, 1);
    chk("R7 single retry ends at 3.3V", {30'h0, done_o, low_volt_o}, 32'h2);

    // Op-cond error
    caps(1, 5'b00001, 3'b000, 24'h0, 0);
    attach();
    reply(32'h0, 0, 1);
    reply(32'h0, 1, 1);
    chk("R8 err on opcond", {29'h0, done_o, err_o, cmd_req_o}, 32'h6);
    repeat (3) @(negedge clk);
    chk("R8 err sticky", 32'(err_o), 1);
    reply(32'hFFFF_FFFF, 0, 0);
    chk("R10 idle strobe ignored", {30'h0, cmd_req_o, err_o}, 32'h1);

    // Error on the 3.3 V step; attach clears err
    attach();
    chk("R2 attach clears err", 32'(err_o), 0);
    reply(32'h0, 1, 1);
    chk("R8 err on 3.3V step", {30'h0, done_o, err_o}, 32'h3);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule